// File: doc/BRIEF.md
# Parallel NOR Flash Command Interpreter

This block is the command front end of a byte-wide parallel NOR flash. It watches bus write cycles (address, data byte, write strobe) and turns them into mode changes and operations. These are identification mode, a query mode, byte program, erase of a whole chip, and erase of one or more sectors with suspend and resume. It holds the current base mode, a flag per sector that is waiting to be erased, and a busy indication. For a given read address it reports whether a read would see array contents. Erase and program durations are counted in clock cycles, not modelled in analog terms.

Commands are recognised from the low address bits only, so firmware that writes unlock bytes at aliased high addresses still works. The sector map is not uniform: every main sector is one large block, except the highest, which is cut into four boot sectors. A system bus master drives `we`, `addr` and `wdata` directly, and samples `mode_o`, `busy_o` and `array_ok_o` to steer its reads.

Top module: `pnor_cmd_ctrl`

## Requirements
- R1: After reset, mode_o is 0 (array read), busy_o and susp_o are 0, every erase flag is 0 and array_ok_o is 1.
- R2: Writes of 0xAA at offset 0x555, 0x55 at offset 0x2AA and 0x90 at offset 0x555 set mode_o to 1 (identification). Offsets are compared using only the low CMD_W (11) address bits, so higher address bits have no effect on decoding.
- R3: A write whose data or offset does not match the next expected unlock step abandons the sequence. mode_o keeps its value, and a following command byte on its own has no effect.
- R4: 0x98 at offset 0x055 from mode 0 or 1 sets mode_o to 2 (query) and remembers the previous mode. 0xF0 in mode 2 restores that remembered mode, and 0xF0 in any other mode gives mode 0. Unlock sequences are ignored in mode 2.
- R5: After the unlock pair and 0xA0 at 0x555, the next write starts a program. busy_o is then 1 for exactly PROG_CYC cycles.
- R6: After the unlock pair, 0x80 at 0x555, a second unlock pair and 0x10 at 0x555, all erase flags become 1 and busy_o stays 1 until every flag has cleared.
- R7: After the same erase preamble, 0x30 at any address in a sector sets that sector's flag. Each further 0x30 written less than WIN_CYC cycles after the last accepted one adds its sector. Once WIN_CYC cycles pass with no addition the erase runs, and later 0x30 writes add nothing.
- R8: A running erase clears flagged sectors one at a time, lowest index first. Each sector takes ERASE_CYC cycles of running time.
- R9: 0xF0 written while an erase is in its collection window or running is ignored: mode_o, the flags and busy_o are unchanged.
- R10: 0xB0 during a running erase sets susp_o to 1 and busy_o to 0, and freezes the flags. 0x30 while suspended resumes (susp_o 0, busy_o 1). 0xB0 when no erase runs has no effect.
- R11: array_ok_o is 1 exactly when mode_o is 0, busy_o is 0, and either no erase is suspended or the sector holding rd_addr is not flagged.
- R12: Sector indices: address bits above MAIN_W give indices 0 to 14 for the main sectors. The top main block is split in ascending address order into a 1/2 block (index 15), two 1/8 blocks (16, 17) and a 1/4 block (18). Flag bit n of erase_flags_o belongs to sector n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| we | input | 1 | Write strobe, one write per cycle it is high |
| addr | input | ADDR_W (20) | Write address |
| wdata | input | 8 | Write data byte |
| rd_addr | input | ADDR_W (20) | Address of a read being considered |
| mode_o | output | 2 | Base mode: 0 array, 1 identification, 2 query |
| busy_o | output | 1 | Program or erase in progress (not while suspended) |
| susp_o | output | 1 | Erase suspended |
| erase_flags_o | output | NSEC (19) | Sectors still waiting to be erased |
| array_ok_o | output | 1 | A read at rd_addr would return array data |

## Verification
The bench aims at decoding that looks at too many address bits: unlock bytes are sent at aliased addresses, and a design that compares full addresses would stay in array mode. It checks the order of entering identification, then query, then leaving, since a design that drops the remembered mode falls back to array mode too early. Reset bytes are sent during a chip erase and during a sector collection window, where a faulty design would clear the flags or the mode. A three-sector erase with boot sectors is suspended and resumed, and the interval between flag clears is timed. This catches frozen flags that still move, a wrong clearing order, late 0x30 writes that get accepted, and boot sector boundaries that are off.

// File: rtl/nfc_pkg.sv
package nfc_pkg;

  typedef enum logic [1:0] {
    M_READ = 2'd0,
    M_AUTO = 2'd1,
    M_CFI  = 2'd2
  } base_mode_t;

  typedef enum logic [1:0] {
    E_IDLE,
    E_WINDOW,
    E_RUN,
    E_SUSP
  } erase_st_t;

  typedef enum logic [2:0] {
    S_IDLE,
    S_U1,
    S_U2,
    S_PRG,
    S_ES,
    S_EU1,
    S_EU2
  } seq_st_t;

  localparam logic [7:0] C_UNL1  = 8'hAA;
  localparam logic [7:0] C_UNL2  = 8'h55;
  localparam logic [7:0] C_AUTO  = 8'h90;
  localparam logic [7:0] C_PROG  = 8'hA0;
  localparam logic [7:0] C_ESET  = 8'h80;
  localparam logic [7:0] C_CHIP  = 8'h10;
  localparam logic [7:0] C_SECT  = 8'h30;
  localparam logic [7:0] C_SUSP  = 8'hB0;
  localparam logic [7:0] C_RESET = 8'hF0;
  localparam logic [7:0] C_QUERY = 8'h98;

  localparam int unsigned OFF_A = 32'h555;
  localparam int unsigned OFF_B = 32'h2AA;
  localparam int unsigned OFF_Q = 32'h055;

endpackage

// File: rtl/nfc_sector_map.sv
module nfc_sector_map #(
  parameter int ADDR_W = 20,
  parameter int MAIN_W = 16,
  parameter int NSEC   = 19,
  parameter int SEC_W  = 5
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [SEC_W-1:0]  sec_o
);
  localparam int TOP_W = ADDR_W - MAIN_W;
  localparam int NMAIN = (1 << TOP_W) - 1;

  // Main blocks map by their upper bits; the highest block is split into
  // 1/2, 1/8, 1/8, 1/4 pieces in ascending address order.
  function automatic logic [SEC_W-1:0] sector_of(input logic [ADDR_W-1:0] a);
    logic [TOP_W-1:0]  blk;
    logic [MAIN_W-1:0] off;
    blk = a[ADDR_W-1:MAIN_W];
    off = a[MAIN_W-1:0];
    if (blk != '1)        return SEC_W'(blk);
    if (!off[MAIN_W-1])   return SEC_W'(NMAIN);
    if (off[MAIN_W-2])    return SEC_W'(NMAIN + 3);
    if (off[MAIN_W-3])    return SEC_W'(NMAIN + 2);
    return SEC_W'(NMAIN + 1);
  endfunction

  assign sec_o = sector_of(addr_i);

  // R12
  always_comb begin
    sec_in_range_chk: assert (int'(sec_o) < NSEC);
  end
endmodule

// File: rtl/nfc_cmd_seq.sv
module nfc_cmd_seq
  import nfc_pkg::*;
#(
  parameter int CMD_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             we_i,
  input  logic [CMD_W-1:0] off_i,
  input  logic [7:0]       data_i,
  output logic             ev_auto_o,
  output logic             ev_prog_o,
  output logic             ev_chip_o,
  output logic             ev_sect_o,
  output logic             prog_armed_o
);
  localparam logic [CMD_W-1:0] OFS_A = CMD_W'(OFF_A);
  localparam logic [CMD_W-1:0] OFS_B = CMD_W'(OFF_B);

  seq_st_t st_q, st_d;

  function automatic logic match(input logic [CMD_W-1:0] o, input logic [7:0] d,
                                 input logic [CMD_W-1:0] eo, input logic [7:0] ed);
    return (o == eo) && (d == ed);
  endfunction

  always_comb begin
    st_d      = st_q;
    ev_auto_o = 1'b0;
    ev_prog_o = 1'b0;
    ev_chip_o = 1'b0;
    ev_sect_o = 1'b0;
    if (!en_i) begin
      st_d = S_IDLE;
    end else if (we_i) begin
      case (st_q)
        S_IDLE: st_d = match(off_i, data_i, OFS_A, C_UNL1) ? S_U1 : S_IDLE;
        S_U1:   st_d = match(off_i, data_i, OFS_B, C_UNL2) ? S_U2 : S_IDLE;
        S_U2: begin
          st_d = S_IDLE;
          if (match(off_i, data_i, OFS_A, C_AUTO))      ev_auto_o = 1'b1;
          else if (match(off_i, data_i, OFS_A, C_PROG)) st_d = S_PRG;
          else if (match(off_i, data_i, OFS_A, C_ESET)) st_d = S_ES;
        end
        S_PRG: begin
          ev_prog_o = 1'b1;
          st_d      = S_IDLE;
        end
        S_ES:   st_d = match(off_i, data_i, OFS_A, C_UNL1) ? S_EU1 : S_IDLE;
        S_EU1:  st_d = match(off_i, data_i, OFS_B, C_UNL2) ? S_EU2 : S_IDLE;
        S_EU2: begin
          st_d = S_IDLE;
          if (match(off_i, data_i, OFS_A, C_CHIP)) ev_chip_o = 1'b1;
          else if (data_i == C_SECT)               ev_sect_o = 1'b1;
        end
        default: st_d = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= S_IDLE;
    else        st_q <= st_d;
  end

  assign prog_armed_o = (st_q == S_PRG);

  // R3
  abort_on_bad_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_U1 && en_i && we_i && off_i != OFS_B) |=> (st_q == S_IDLE));

  // R2
  event_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ev_auto_o, ev_prog_o, ev_chip_o, ev_sect_o}));
endmodule

// File: rtl/nfc_erase_eng.sv
module nfc_erase_eng
  import nfc_pkg::*;
#(
  parameter int NSEC      = 19,
  parameter int SEC_W     = 5,
  parameter int ERASE_CYC = 40,
  parameter int WIN_CYC   = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we_i,
  input  logic [7:0]       data_i,
  input  logic [SEC_W-1:0] sec_i,
  input  logic             ev_chip_i,
  input  logic             ev_sect_i,
  output logic [NSEC-1:0]  flags_o,
  output logic             erasing_o,
  output logic             susp_o
);
  localparam int WCW = $clog2(WIN_CYC + 1);
  localparam int ECW = $clog2(ERASE_CYC + 1);

  erase_st_t        st_q;
  logic [NSEC-1:0]  flags_q;
  logic [WCW-1:0]   wcnt_q;
  logic [ECW-1:0]   ecnt_q;
  logic [SEC_W-1:0] cur_sec;
  logic [NSEC-1:0]  left_after;
  logic             add_req, susp_req, res_req, sec_done, win_over;

  function automatic logic [NSEC-1:0] sec_bit(input logic [SEC_W-1:0] s);
    return NSEC'(1) << s;
  endfunction

  function automatic logic [SEC_W-1:0] lowest_set(input logic [NSEC-1:0] f);
    logic [SEC_W-1:0] r;
    r = '0;
    for (int i = NSEC - 1; i >= 0; i--) if (f[i]) r = SEC_W'(i);
    return r;
  endfunction

  assign cur_sec    = lowest_set(flags_q);
  assign left_after = flags_q & ~sec_bit(cur_sec);
  assign add_req    = we_i && (data_i == C_SECT) && (st_q == E_WINDOW);
  assign susp_req   = we_i && (data_i == C_SUSP) && (st_q == E_RUN);
  assign res_req    = we_i && (data_i == C_SECT) && (st_q == E_SUSP);
  assign sec_done   = (st_q == E_RUN) && (ecnt_q == ECW'(ERASE_CYC - 1));
  assign win_over   = (wcnt_q == WCW'(WIN_CYC - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= E_IDLE;
      flags_q <= '0;
      wcnt_q  <= '0;
      ecnt_q  <= '0;
    end else begin
      case (st_q)
        E_IDLE: begin
          if (ev_chip_i) begin
            flags_q <= '1;
            ecnt_q  <= '0;
            st_q    <= E_RUN;
          end else if (ev_sect_i) begin
            flags_q <= sec_bit(sec_i);
            wcnt_q  <= '0;
            st_q    <= E_WINDOW;
          end
        end
        E_WINDOW: begin
          if (add_req) begin
            flags_q <= flags_q | sec_bit(sec_i);
            wcnt_q  <= '0;
          end else if (win_over) begin
            ecnt_q <= '0;
            st_q   <= E_RUN;
          end else begin
            wcnt_q <= wcnt_q + 1'b1;
          end
        end
        E_RUN: begin
          if (susp_req) begin
            st_q <= E_SUSP;
          end else if (sec_done) begin
            flags_q <= left_after;
            ecnt_q  <= '0;
            if (left_after == '0) st_q <= E_IDLE;
          end else begin
            ecnt_q <= ecnt_q + 1'b1;
          end
        end
        E_SUSP: if (res_req) st_q <= E_RUN;
        default: st_q <= E_IDLE;
      endcase
    end
  end

  assign flags_o   = flags_q;
  assign erasing_o = (st_q == E_WINDOW) || (st_q == E_RUN);
  assign susp_o    = (st_q == E_SUSP);

  // R10
  frozen_while_susp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == E_SUSP) |=> $stable(flags_q));

  // R8
  run_has_work_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == E_RUN) |-> (flags_q != '0));

  // R8
  single_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == E_RUN) |=> ($countones($past(flags_q) & ~flags_q) <= 1));
endmodule

// File: rtl/pnor_cmd_ctrl.sv
module pnor_cmd_ctrl
  import nfc_pkg::*;
#(
  parameter int ADDR_W    = 20,
  parameter int MAIN_W    = 16,
  parameter int CMD_W     = 11,
  parameter int PROG_CYC  = 8,
  parameter int ERASE_CYC = 40,
  parameter int WIN_CYC   = 16,
  localparam int NMAIN    = (1 << (ADDR_W - MAIN_W)) - 1,
  localparam int NSEC     = NMAIN + 4,
  localparam int SEC_W    = $clog2(NSEC)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [1:0]        mode_o,
  output logic              busy_o,
  output logic              susp_o,
  output logic [NSEC-1:0]   erase_flags_o,
  output logic              array_ok_o
);
  localparam int PCW = $clog2(PROG_CYC + 1);
  localparam logic [CMD_W-1:0] OFS_Q = CMD_W'(OFF_Q);

  // index 0: write address, index 1: read address
  logic [ADDR_W-1:0] map_a [2];
  logic [SEC_W-1:0]  map_s [2];
  assign map_a[0] = addr;
  assign map_a[1] = rd_addr;

  for (genvar g = 0; g < 2; g++) begin : g_map
    nfc_sector_map #(
      .ADDR_W(ADDR_W), .MAIN_W(MAIN_W), .NSEC(NSEC), .SEC_W(SEC_W)
    ) u_map (
      .addr_i(map_a[g]),
      .sec_o (map_s[g])
    );
  end

  base_mode_t     mode_q, saved_q;
  logic           prog_busy_q;
  logic [PCW-1:0] pcnt_q;
  logic           ev_auto, ev_prog, ev_chip, ev_sect, prog_armed;
  logic           erasing, susp, seq_en, f0_acc, q_hit;
  logic [NSEC-1:0] flags;

  assign seq_en = !erasing && !susp && !prog_busy_q && (mode_q != M_CFI);

  nfc_cmd_seq #(.CMD_W(CMD_W)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .en_i        (seq_en),
    .we_i        (we),
    .off_i       (addr[CMD_W-1:0]),
    .data_i      (wdata),
    .ev_auto_o   (ev_auto),
    .ev_prog_o   (ev_prog),
    .ev_chip_o   (ev_chip),
    .ev_sect_o   (ev_sect),
    .prog_armed_o(prog_armed)
  );

  nfc_erase_eng #(
    .NSEC(NSEC), .SEC_W(SEC_W), .ERASE_CYC(ERASE_CYC), .WIN_CYC(WIN_CYC)
  ) u_erase (
    .clk      (clk),
    .rst_n    (rst_n),
    .we_i     (we),
    .data_i   (wdata),
    .sec_i    (map_s[0]),
    .ev_chip_i(ev_chip),
    .ev_sect_i(ev_sect),
    .flags_o  (flags),
    .erasing_o(erasing),
    .susp_o   (susp)
  );

  // Single-cycle commands that need no unlock.
  assign f0_acc = we && (wdata == C_RESET) && !prog_armed && !erasing;
  assign q_hit  = we && (wdata == C_QUERY) && (addr[CMD_W-1:0] == OFS_Q) &&
                  !prog_armed && !erasing && !susp && (mode_q != M_CFI);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q  <= M_READ;
      saved_q <= M_READ;
    end else if (ev_auto) begin
      mode_q <= M_AUTO;
    end else if (q_hit) begin
      saved_q <= mode_q;
      mode_q  <= M_CFI;
    end else if (f0_acc) begin
      mode_q <= (mode_q == M_CFI) ? saved_q : M_READ;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prog_busy_q <= 1'b0;
      pcnt_q      <= '0;
    end else if (ev_prog) begin
      prog_busy_q <= 1'b1;
      pcnt_q      <= PCW'(PROG_CYC - 1);
    end else if (prog_busy_q) begin
      if (pcnt_q == '0) prog_busy_q <= 1'b0;
      else              pcnt_q      <= pcnt_q - 1'b1;
    end
  end

  assign mode_o        = mode_q;
  assign busy_o        = erasing || prog_busy_q;
  assign susp_o        = susp;
  assign erase_flags_o = flags;
  assign array_ok_o    = (mode_q == M_READ) && !busy_o && !(susp && flags[map_s[1]]);

  // R9
  reset_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (erasing && we && wdata == C_RESET) |=> $stable(mode_q));

  // R4
  query_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_CFI && f0_acc) |=> (mode_q == $past(saved_q)));

  // R2
  auto_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_auto |=> (mode_q == M_AUTO));

  // R5
  prog_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_prog |=> busy_o);
endmodule

// File: tb/test_pnor_cmd_ctrl.sv
module test_pnor_cmd_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 20;
  localparam int PROG_CYC   = 8;
  localparam int ERASE_CYC  = 40;
  localparam int WIN_CYC    = 16;
  localparam int NSEC       = 19;
  localparam int NVEC       = 29;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic we = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [ADDR_W-1:0] rd_addr = '0;
  logic [7:0] wdata = '0;
  logic [1:0] mode_o;
  logic busy_o, susp_o, array_ok_o;
  logic [NSEC-1:0] erase_flags_o;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  pnor_cmd_ctrl #(
    .ADDR_W(ADDR_W), .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC), .WIN_CYC(WIN_CYC)
  ) i_pnor_cmd_ctrl (
    .clk(clk), .rst_n(rst_n), .we(we), .addr(addr), .wdata(wdata),
    .rd_addr(rd_addr), .mode_o(mode_o), .busy_o(busy_o), .susp_o(susp_o),
    .erase_flags_o(erase_flags_o), .array_ok_o(array_ok_o)
  );

  // {req[3:0], addr[19:0], data[7:0], expected mode[1:0]}
  localparam logic [33:0] VEC [NVEC] = '{
    {4'd2, 20'h00555, 8'hAA, 2'd0}, {4'd2, 20'h002AA, 8'h55, 2'd0},
    {4'd2, 20'h00555, 8'h90, 2'd1}, {4'd4, 20'h00055, 8'h98, 2'd2},
    {4'd4, 20'h00000, 8'hF0, 2'd1}, {4'd4, 20'h00000, 8'hF0, 2'd0},
    {4'd4, 20'h00055, 8'h98, 2'd2}, {4'd4, 20'h00123, 8'hF0, 2'd0},
    {4'd2, 20'hAB555, 8'hAA, 2'd0}, {4'd2, 20'h352AA, 8'h55, 2'd0},
    {4'd2, 20'hFF555, 8'h90, 2'd1}, {4'd4, 20'h00000, 8'hF0, 2'd0},
    {4'd3, 20'h00555, 8'hAA, 2'd0}, {4'd3, 20'h002AB, 8'h55, 2'd0},
    {4'd3, 20'h00555, 8'h90, 2'd0}, {4'd3, 20'h00555, 8'hAA, 2'd0},
    {4'd3, 20'h002AA, 8'h55, 2'd0}, {4'd3, 20'h00555, 8'h77, 2'd0},
    {4'd2, 20'h00555, 8'hAA, 2'd0}, {4'd2, 20'h002AA, 8'h55, 2'd0},
    {4'd2, 20'h00555, 8'h90, 2'd1}, {4'd4, 20'h00055, 8'h98, 2'd2},
    {4'd4, 20'h00555, 8'hAA, 2'd2}, {4'd4, 20'h002AA, 8'h55, 2'd2},
    {4'd4, 20'h00555, 8'h90, 2'd2}, {4'd4, 20'h00000, 8'hF0, 2'd1},
    {4'd4, 20'h00000, 8'hF0, 2'd0}, {4'd4, 20'h00855, 8'h98, 2'd2},
    {4'd4, 20'h00000, 8'hF0, 2'd0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Called at a falling edge; returns at the next falling edge.
  task automatic wr(input logic [ADDR_W-1:0] a, input logic [7:0] d);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic unlock();
    wr(20'h00555, 8'hAA);
    wr(20'h002AA, 8'h55);
  endtask

  task automatic erase_pre();
    unlock();
    wr(20'h00555, 8'h80);
    unlock();
  endtask

  task automatic wait_flag_change(output int n);
    logic [NSEC-1:0] prev;
    prev = erase_flags_o;
    n = 0;
    while (erase_flags_o == prev && n < 2000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic wait_idle();
    int n;
    n = 0;
    while (busy_o && n < 4000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic finish_tb();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_tb();
  end

  initial begin
    logic [NSEC-1:0] three;
    int n;
    three = (NSEC'(1) << 3) | (NSEC'(1) << 16) | (NSEC'(1) << 18);

    // R1 reset state
    repeat (3) @(negedge clk);
    chk("R1 mode", 32'(mode_o), 0);
    chk("R1 busy", 32'(busy_o), 0);
    chk("R1 susp", 32'(susp_o), 0);
    chk("R1 flags", 32'(erase_flags_o), 0);
    chk("R1 array_ok", 32'(array_ok_o), 1);
    rst_n = 1'b1;

    // R2 R3 R4 mode vectors
    for (int i = 0; i < NVEC; i++) begin
      wr(VEC[i][29:10], VEC[i][9:2]);
      chk($sformatf("R%0d vec%0d mode", VEC[i][33:30], i), 32'(mode_o), 32'(VEC[i][1:0]));
    end

    // R5 program duration
    unlock();
    wr(20'h00555, 8'hA0);
    chk("R5 armed not busy", 32'(busy_o), 0);
    wr(20'h12345, 8'h5A);
    chk("R5 busy start", 32'(busy_o), 1);
    chk("R11 no array while programming", 32'(array_ok_o), 0);
    repeat (PROG_CYC - 1) @(negedge clk);
    chk("R5 busy last cycle", 32'(busy_o), 1);
    @(negedge clk);
    chk("R5 busy end", 32'(busy_o), 0);

    // R6 chip erase from identification mode, R9 reset ignored
    unlock();
    wr(20'h00555, 8'h90);
    chk("R2 ident before chip erase", 32'(mode_o), 1);
    erase_pre();
    wr(20'h00555, 8'h10);
    chk("R6 all flags", 32'(erase_flags_o), 32'(NSEC'('1)));
    chk("R6 busy", 32'(busy_o), 1);
    wr(20'h00000, 8'hF0);
    chk("R9 mode kept in erase", 32'(mode_o), 1);
    chk("R9 flags kept", 32'(erase_flags_o), 32'(NSEC'('1)));
    chk("R9 busy kept", 32'(busy_o), 1);
    wait_idle();
    chk("R6 done flags", 32'(erase_flags_o), 0);
    chk("R6 done busy", 32'(busy_o), 0);
    wr(20'h00000, 8'hF0);
    chk("R4 back to array", 32'(mode_o), 0);

    // R7 R12 three-sector erase with boot sectors
    erase_pre();
    wr(20'h30000, 8'h30);
    chk("R7 first sector", 32'(erase_flags_o), 32'(NSEC'(1) << 3));
    wr(20'hF9FFF, 8'h30);
    chk("R12 boot 8K sector", 32'(erase_flags_o), 32'((NSEC'(1) << 3) | (NSEC'(1) << 16)));
    wr(20'hFC000, 8'h30);
    chk("R7 three sectors", 32'(erase_flags_o), 32'(three));
    repeat (WIN_CYC + 2) @(negedge clk);
    wr(20'h50000, 8'h30);
    chk("R7 late add refused", 32'(erase_flags_o), 32'(three));
    wr(20'h00000, 8'hF0);
    chk("R9 flags in run", 32'(erase_flags_o), 32'(three));
    chk("R9 busy in run", 32'(busy_o), 1);
    chk("R9 mode in run", 32'(mode_o), 0);

    // R10 suspend
    wr(20'h00000, 8'hB0);
    chk("R10 susp set", 32'(susp_o), 1);
    chk("R10 busy low", 32'(busy_o), 0);
    rd_addr = 20'h50000; #1;
    chk("R11 other sector readable", 32'(array_ok_o), 1);
    rd_addr = 20'hF8000; #1;
    chk("R12 R11 sector 16 blocked", 32'(array_ok_o), 0);
    rd_addr = 20'hF7FFF; #1;
    chk("R12 R11 sector 15 readable", 32'(array_ok_o), 1);
    rd_addr = 20'hFA000; #1;
    chk("R12 R11 sector 17 readable", 32'(array_ok_o), 1);
    rd_addr = 20'hFFFFF; #1;
    chk("R12 R11 sector 18 blocked", 32'(array_ok_o), 0);
    repeat (60) @(negedge clk);
    chk("R10 flags frozen", 32'(erase_flags_o), 32'(three));
    wr(20'h00000, 8'h30);
    chk("R10 resumed", 32'(susp_o), 0);
    chk("R10 busy again", 32'(busy_o), 1);

    // R8 order and per-sector time
    wait_flag_change(n);
    chk("R8 lowest first", 32'(erase_flags_o), 32'(three & ~(NSEC'(1) << 3)));
    wait_flag_change(n);
    chk("R8 second clear", 32'(erase_flags_o), 32'(NSEC'(1) << 18));
    chk("R8 sector cycles", 32'(n), 32'(ERASE_CYC));
    wait_idle();
    chk("R8 all clear", 32'(erase_flags_o), 0);
    chk("R1 array_ok after erase", 32'(array_ok_o), 1);

    // R10 suspend with no erase
    wr(20'h00000, 8'hB0);
    chk("R10 idle suspend ignored", 32'(susp_o), 0);

    // R9 reset during collection window
    erase_pre();
    wr(20'h10000, 8'h30);
    wr(20'h00000, 8'hF0);
    chk("R9 window flags kept", 32'(erase_flags_o), 32'(NSEC'(1) << 1));
    chk("R9 window busy kept", 32'(busy_o), 1);
    wait_idle();
    chk("R7 single sector done", 32'(erase_flags_o), 0);

    finish_tb();
  end
endmodule